// File: doc/BRIEF.md
# Packed Byte Dot-Product Accumulate Unit

This arithmetic unit treats each of two 32-bit operands as four 8-bit lanes, multiplies lane against matching lane, and adds the four products into a result whose width is a parameter (32 or 64 bits). A 3-bit operation code chooses how the lanes are read: both signed, both unsigned, or mixed (first operand signed, second unsigned). The same code chooses between a plain dot product, which wraps to the result width, and a dot product whose final addition to an accumulator operand clamps at the limits of the result type. The clamp is signed for the signed and mixed readings and unsigned for the unsigned reading.

Operands enter through a valid/ready stream and the result leaves through a second valid/ready stream, with one register stage between them. An operation is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on the next cycle with `out_valid` high and stays there, unchanged, until a clock edge where `out_ready` is high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. Operands may therefore stream at one per cycle while the consumer keeps `out_ready` high. Holding `out_ready` low stalls the input side without losing the result.

Top module: `pdp_dot_unit`

## Requirements
- R1: Lane k of an operand is bits 8k+7 down to 8k, for k = 0 to 3. Lane k of `in_a` multiplies only lane k of `in_b`.
- R2: Operation code mode bits `in_op[1:0]` = 2'b00 (codes 3'b000 and 3'b100) sign-extend every lane of both operands.
- R3: Mode bits 2'b10 (codes 3'b010 and 3'b110) zero-extend every lane of both operands. Mode bits 2'b11 (codes 3'b011 and 3'b111) act exactly like 2'b10.
- R4: Mode bits 2'b01 (codes 3'b001 and 3'b101) sign-extend the lanes of `in_a` and zero-extend the lanes of `in_b`.
- R5: When `in_op[2]` = 0, the result is the low RES_W bits of the exact sum of the four products, and `in_acc` has no effect.
- R6: When `in_op[2]` = 1 and the mode is signed or mixed, the result is `in_acc` + dot sum as RES_W-bit two's complement values. A sum above the largest RES_W-bit signed value gives that value, and a sum below the smallest gives the smallest.
- R7: When `in_op[2]` = 1 and the mode is unsigned, the result is `in_acc` + dot sum as unsigned values, clamped to all ones when it exceeds 2^RES_W - 1.
- R8: With RES_W = 64 the same operands give the exact result at 64 bits. In particular, a negative dot sum from a non-saturating code is sign-extended across all 64 bits.
- R9: An operation taken on a clock edge shows `out_valid` high and its result on `out_result` after that edge. With `out_ready` high and no new operation, `out_valid` falls after the following edge.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid` and `out_result` hold their values.
- R11: A synchronous active-high `rst` clears `out_valid`. After reset, `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and operation code are valid |
| in_ready | output | 1 | Unit can accept an operation this cycle |
| in_op | input | 3 | Bit 2: saturating accumulate; bits 1:0: lane signedness mode |
| in_a | input | 32 | First packed operand, four 8-bit lanes |
| in_b | input | 32 | Second packed operand, four 8-bit lanes |
| in_acc | input | RES_W | Accumulator for the saturating codes |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | RES_W | Dot-product or saturated accumulate result |

## Verification
The bench builds two copies side by side: one with RES_W = 32 and one with RES_W = 64. Both receive identical operands, and the 32-bit copy sees the low half of a shared 64-bit accumulator. The 32-bit copy puts the signed and unsigned clamps within reach of moderate accumulator values. The 64-bit copy shows the dot sum sign-extended into the upper word and clamps at the 64-bit limits. One accumulator value can clamp in one width and not in the other, so the width dependence of the saturation is visible within a single operation.

// File: rtl/pdp_pkg.sv
package pdp_pkg;

  localparam int unsigned OPND_W = 32;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = OPND_W / LANE_W;
  localparam int unsigned OP_W   = 3;

  typedef struct packed {
    logic       sat;
    logic [1:0] mode;
  } pdp_op_t;

  // Signed lanes on the first operand for every mode except the unsigned ones.
  function automatic logic a_is_signed(input logic [1:0] mode);
    return ~mode[1];
  endfunction

  // Signed lanes on the second operand only for the fully signed mode.
  function automatic logic b_is_signed(input logic [1:0] mode);
    return (mode == 2'b00);
  endfunction

endpackage

// File: rtl/pdp_lane_ext.sv
module pdp_lane_ext #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned RES_W  = 32
) (
  input  logic [LANES*LANE_W-1:0]     opnd,
  input  logic                        is_signed,
  output logic [LANES-1:0][RES_W-1:0] ext
);

  localparam int unsigned PAD_W = RES_W - LANE_W;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] raw;
    logic              fill;
    assign raw    = opnd[k*LANE_W +: LANE_W];
    assign fill   = is_signed & raw[LANE_W-1];
    assign ext[k] = {{PAD_W{fill}}, raw};
  end

endmodule

// File: rtl/pdp_reduce.sv
module pdp_reduce #(
  parameter int unsigned LANES = 4,
  parameter int unsigned RES_W = 32
) (
  input  logic [LANES-1:0][RES_W-1:0] ea,
  input  logic [LANES-1:0][RES_W-1:0] eb,
  output logic [RES_W-1:0]            dot
);

  logic [LANES-1:0][RES_W-1:0] prod;

  for (genvar k = 0; k < LANES; k++) begin : g_mul
    assign prod[k] = ea[k] * eb[k];
  end

  always_comb begin
    logic [RES_W-1:0] tot;
    tot = '0;
    for (int k = 0; k < LANES; k++) begin
      tot = tot + prod[k];
    end
    dot = tot;
  end

endmodule

// File: rtl/pdp_sat_acc.sv
module pdp_sat_acc #(
  parameter int unsigned RES_W = 32
) (
  input  logic [RES_W-1:0] dot,
  input  logic [RES_W-1:0] acc,
  input  logic             sat_en,
  input  logic             signed_clamp,
  output logic [RES_W-1:0] res
);

  localparam int unsigned MSB = RES_W - 1;
  localparam logic [RES_W-1:0] S_MAX = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic [RES_W-1:0] S_MIN = {1'b1, {(RES_W-1){1'b0}}};
  localparam logic [RES_W-1:0] U_MAX = {RES_W{1'b1}};

  logic [RES_W:0]   wide;
  logic [RES_W-1:0] raw;
  logic             carry, ovf_pos, ovf_neg;

  assign wide    = {1'b0, acc} + {1'b0, dot};
  assign raw     = wide[RES_W-1:0];
  assign carry   = wide[RES_W];
  assign ovf_pos = ~acc[MSB] & ~dot[MSB] &  raw[MSB];
  assign ovf_neg =  acc[MSB] &  dot[MSB] & ~raw[MSB];

  always_comb begin
    if (!sat_en) begin
      res = dot;
    end else if (signed_clamp) begin
      if (ovf_pos)      res = S_MAX;
      else if (ovf_neg) res = S_MIN;
      else              res = raw;
    end else begin
      res = carry ? U_MAX : raw;
    end
  end

endmodule

// File: rtl/pdp_dot_unit.sv
module pdp_dot_unit #(
  parameter int unsigned RES_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [pdp_pkg::OP_W-1:0]   in_op,
  input  logic [pdp_pkg::OPND_W-1:0] in_a,
  input  logic [pdp_pkg::OPND_W-1:0] in_b,
  input  logic [RES_W-1:0]           in_acc,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [RES_W-1:0]           out_result
);

  import pdp_pkg::*;

  pdp_op_t                     op;
  logic [LANES-1:0][RES_W-1:0] ext_a, ext_b;
  logic [RES_W-1:0]            dot, res_d, res_q;
  logic                        vld_q, take;

  assign op = pdp_op_t'(in_op);

  pdp_lane_ext #(.LANES(LANES), .LANE_W(LANE_W), .RES_W(RES_W)) ext_a_i (
    .opnd      (in_a),
    .is_signed (a_is_signed(op.mode)),
    .ext       (ext_a)
  );

  pdp_lane_ext #(.LANES(LANES), .LANE_W(LANE_W), .RES_W(RES_W)) ext_b_i (
    .opnd      (in_b),
    .is_signed (b_is_signed(op.mode)),
    .ext       (ext_b)
  );

  pdp_reduce #(.LANES(LANES), .RES_W(RES_W)) red_i (
    .ea  (ext_a),
    .eb  (ext_b),
    .dot (dot)
  );

  pdp_sat_acc #(.RES_W(RES_W)) sat_i (
    .dot          (dot),
    .acc          (in_acc),
    .sat_en       (op.sat),
    .signed_clamp (a_is_signed(op.mode)),
    .res          (res_d)
  );

  assign in_ready = ~vld_q | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
    end else if (take) begin
      vld_q <= 1'b1;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) res_q <= res_d;
  end

  assign out_valid  = vld_q;
  assign out_result = res_q;

endmodule

// File: rtl/pdp_dot_unit_chk.sv
module pdp_dot_unit_chk #(
  parameter int unsigned RES_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [2:0]       in_op,
  input logic [RES_W-1:0] in_acc,
  input logic             out_valid,
  input logic             out_ready,
  input logic [RES_W-1:0] out_result
);

  logic [2:0]       cap_op;
  logic [RES_W-1:0] cap_acc;
  logic             rst_q = 1'b0;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (in_valid && in_ready) begin
      cap_op  <= in_op;
      cap_acc <= in_acc;
    end
  end

  // R11: one edge after reset was sampled, the output is empty
  always_ff @(posedge clk) begin
    if (rst_q) a_r11_reset_clears: assert (!out_valid);
  end

  // R9: a taken operation is presented on the next cycle
  a_r9_latency: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R10: a stalled result stays put
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  // R10: no new operation is taken over a stalled result
  a_r10_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R3: an unsigned wrapping dot sum never exceeds 4*255*255 < 2^18
  a_r3_udot_range: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cap_op == 3'b010) |-> ((out_result >> 18) == '0));

  // R7: an unsigned saturating accumulate never lands below the accumulator
  a_r7_unsigned_floor: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cap_op[2] && cap_op[1]) |-> (out_result >= cap_acc));

endmodule

bind pdp_dot_unit pdp_dot_unit_chk #(.RES_W(RES_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .in_acc     (in_acc),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result)
);

// File: tb/pdp_dot_unit_tb_top.sv
module pdp_dot_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, out_ready;
  logic [2:0]  in_op;
  logic [31:0] in_a, in_b;
  logic [63:0] in_acc;
  logic        rdy32, rdy64, ov32, ov64;
  logic [31:0] res32;
  logic [63:0] res64;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pdp_dot_unit #(.RES_W(32)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy32), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_acc(in_acc[31:0]), .out_valid(ov32),
    .out_ready(out_ready), .out_result(res32)
  );

  pdp_dot_unit #(.RES_W(64)) dut64_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy64), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_acc(in_acc), .out_valid(ov64),
    .out_ready(out_ready), .out_result(res64)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [2:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [63:0] acc,
                                        input int w);
    int dsum = 0;
    logic sa, sb;
    logic signed [65:0] ds, ea, e, mx, mn;
    logic [63:0] r;
    sa = ~op[1];
    sb = (op[1:0] == 2'b00);
    for (int k = 0; k < 4; k++) begin
      int pa, pb;
      pa = sa ? int'($signed(a[8*k +: 8])) : int'(a[8*k +: 8]);
      pb = sb ? int'($signed(b[8*k +: 8])) : int'(b[8*k +: 8]);
      dsum += pa * pb;
    end
    ds = dsum;
    if (!op[2]) begin
      r = ds[63:0];
    end else begin
      if (w == 32) begin
        ea = sa ? {{34{acc[31]}}, acc[31:0]} : {34'h0, acc[31:0]};
        mx = sa ? 66'sh7FFF_FFFF : 66'shFFFF_FFFF;
      end else begin
        ea = sa ? {{2{acc[63]}}, acc} : {2'b00, acc};
        mx = sa ? 66'sh7FFF_FFFF_FFFF_FFFF : 66'shFFFF_FFFF_FFFF_FFFF;
      end
      mn = sa ? (-mx - 66'sd1) : 66'sd0;
      e = ea + ds;
      if (e > mx)      e = mx;
      else if (e < mn) e = mn;
      r = e[63:0];
    end
    if (w == 32) r = {32'h0, r[31:0]};
    return r;
  endfunction

  // One operation through both copies, consumer always ready.
  task automatic run_op(input string req, input logic [2:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [63:0] acc);
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b1;
    in_op = op; in_a = a; in_b = b; in_acc = acc;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {63'h0, ov32}, 64'h1);
    check(req, {32'h0, res32}, model(op, a, b, acc, 32));
    check(req, res64, model(op, a, b, acc, 64));
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    in_op = '0; in_a = '0; in_b = '0; in_acc = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 out_valid", {62'h0, ov32, ov64}, 64'h0);
    check("R11 in_ready", {62'h0, rdy32, rdy64}, 64'h3);
  endtask

  task automatic t_lanes;
    run_op("R1 weights", 3'b010, 32'h0403_0201, 32'h0101_0101, 64'h0);
    run_op("R1 lane1", 3'b010, 32'h0000_0100, 32'h0000_0300, 64'h0);
    run_op("R1 cross", 3'b010, 32'h0100_0000, 32'h0000_00FF, 64'h0);
    run_op("R1 order", 3'b010, 32'h0102_0304, 32'h0A14_1E28, 64'h0);
  endtask

  task automatic t_signed;
    run_op("R2 mixed signs", 3'b000, 32'h80FF_7F01, 32'h80FF_7F01, 64'h0);
    run_op("R2 R8 negative", 3'b000, 32'hFFFF_FFFF, 32'h0101_0101, 64'h0);
  endtask

  task automatic t_unsigned;
    run_op("R3 max", 3'b010, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'h0);
    run_op("R3 alias", 3'b011, 32'hFFFF_FFFF, 32'h8080_8080, 64'h0);
  endtask

  task automatic t_mixed;
    run_op("R4 neg a", 3'b001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'h0);
    run_op("R4 pos", 3'b001, 32'h0000_007F, 32'h0000_0080, 64'h0);
  endtask

  task automatic t_acc_ignored;
    run_op("R5 sdot acc", 3'b000, 32'h0102_0304, 32'hFEFD_FCFB, 64'h1234_5678_9ABC_DEF0);
    run_op("R5 udot acc", 3'b010, 32'h1111_1111, 32'h2222_2222, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_signed_sat;
    run_op("R6 no clamp", 3'b100, 32'h0505_0505, 32'hFDFD_FDFD, 64'd100);
    run_op("R6 pos 32", 3'b100, 32'h7F7F_7F7F, 32'h7F7F_7F7F, 64'h0000_0000_7FFF_FFF0);
    run_op("R6 pos 64", 3'b100, 32'h7F7F_7F7F, 32'h7F7F_7F7F, 64'h7FFF_FFFF_FFFF_FFF0);
    run_op("R6 neg 32", 3'b100, 32'h8080_8080, 32'h7F7F_7F7F, 64'h0000_0000_8000_0010);
    run_op("R6 neg 64", 3'b100, 32'h8080_8080, 32'h7F7F_7F7F, 64'h8000_0000_0000_0010);
    run_op("R6 mixed neg", 3'b101, 32'h8080_8080, 32'hFFFF_FFFF, 64'h0000_0000_8000_0005);
    run_op("R6 mixed pos", 3'b101, 32'h7F7F_7F7F, 32'hFFFF_FFFF, 64'h7FFF_FFFF_7FFF_FFF0);
  endtask

  task automatic t_unsigned_sat;
    run_op("R7 clamp 32", 3'b110, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'h0000_0000_FFFF_FFF0);
    run_op("R7 clamp both", 3'b110, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFA);
    run_op("R7 alias", 3'b111, 32'h8080_8080, 32'hFFFF_FFFF, 64'h0000_0000_FFFF_0000);
    run_op("R7 no clamp", 3'b110, 32'h0102_0304, 32'h0102_0304, 64'd7);
  endtask

  task automatic t_latency;
    run_op("R9 first", 3'b010, 32'h0000_0002, 32'h0000_0003, 64'h0);
    @(negedge clk);
    check("R9 drop", {62'h0, ov32, ov64}, 64'h0);
    // back-to-back stream
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b1;
    in_op = 3'b010; in_a = 32'h0000_0004; in_b = 32'h0000_0005; in_acc = '0;
    @(negedge clk);
    check("R9 stream a", {32'h0, res32}, 64'd20);
    in_a = 32'h0000_0006; in_b = 32'h0000_0007;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 stream b", {32'h0, res32}, 64'd42);
    check("R9 stream valid", {63'h0, ov32}, 64'h1);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b0;
    in_op = 3'b000; in_a = 32'h0000_00FE; in_b = 32'h0000_0009; in_acc = '0;
    @(negedge clk);
    check("R10 ready low", {62'h0, rdy32, rdy64}, 64'h0);
    in_a = 32'h0000_0011; in_b = 32'h0000_0003;
    repeat (2) @(negedge clk);
    check("R10 valid held", {62'h0, ov32, ov64}, 64'h3);
    check("R10 result held", {32'h0, res32}, 64'h0000_0000_FFFF_FFEE);
    check("R10 result held 64", res64, 64'hFFFF_FFFF_FFFF_FFEE);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 next taken", {32'h0, res32}, 64'd51);
    @(negedge clk);
    check("R10 drained", {62'h0, ov32, ov64}, 64'h0);
  endtask

  initial begin
    t_reset;
    t_lanes;
    t_signed;
    t_unsigned;
    t_mixed;
    t_acc_ignored;
    t_signed_sat;
    t_unsigned_sat;
    t_latency;
    t_backpressure;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule